// File: doc/BRIEF.md
# Serial-Programmed Wiper Controller

This block is the digital side of a single-channel potentiometer with 256 positions. A host reaches it through a four-wire serial slave port with an active-low select. Over this port the host can set an 8-bit volatile position register, read that register back, and put the resistor string into a powered-down open state and bring it out again. The position register drives a one-hot bank of tap-switch enables. Two more enables control the high end of the string and a wiper-to-low short.

The serial pins arrive asynchronously. They are resynchronised to the block clock, so each SCK phase must last at least three clock cycles. A frame is 16 bits long: a command byte followed by a data byte, most significant bit first. The command acts only when select is released, and only if the number of clocks received is a non-zero multiple of 16. The serial output always replays the bits received in the previous 16 clocks. Several devices can therefore share one select line, with the output of each device feeding the input of the next.

Top module: `dpot_ctrl`

## Requirements
- R1: After reset the position register holds 128 (0x80), the high-end enable is 1, the wiper-to-low short is 0 and the device is not in shutdown.
- R2: A frame is 16 bits, MSB first, with SDI sampled on each rising SCK edge while select is low. Bits 15:8 are the command and bits 7:0 are the data. Command 0x01 loads the data byte into the position register.
- R3: Command 0x00 leaves the position unchanged. During the next frame, SDO shifts out 0x00 followed by the position register value (16 bits, MSB first).
- R4: Command 0x02 enters shutdown. While in shutdown all tap enables are 0, the high-end enable is 0 and the wiper-to-low short is 1.
- R5: Command 0x03 leaves shutdown and closes the tap of the stored position. A write done during shutdown updates the stored position without closing any tap.
- R6: A command acts only on the rising edge of select, and only if the number of SCK rising edges since select fell is a non-zero multiple of 16. Any other frame leaves the position and the shutdown state unchanged.
- R7: Command bytes 0x04 up to 0xFF leave the position and the shutdown state unchanged.
- R8: SDO changes only after falling SCK edges or when select falls. During a frame it emits, MSB first, the 16 bits most recently received (as modified by a read). In a 32-clock frame, the second half therefore returns the first 16 bits sent, and only the last 16 bits act.
- R9: The SDO output enable is 1 while select is low and 0 while select is high.
- R10: Outside shutdown, exactly one tap enable is 1: the one whose index equals the position register.
- R11: The position register and the shutdown state change only in the cycle after a valid frame has been committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock (mode 0) |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| tap_sel | output | 256 | One-hot tap-switch enables |
| high_en | output | 1 | Connects the high end of the string |
| wl_short | output | 1 | Shorts wiper to the low terminal |

## Verification
The assertions check four properties on every cycle. The tap bank is one-hot at the position while the device is active, and fully open with the short asserted during shutdown. Position and shutdown state hold steady unless a commit occurs, and a commit only follows a select release. SDO moves only after a falling SCK or a select fall. The following can only be shown by the bench's frame sequences: the position is read back one frame later, each command code is decoded correctly, frames with wrong lengths are rejected, and the first half of a double-length frame is forwarded. The bench writes and reads back all 256 positions, and it sends every unused command code.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int unsigned CMD_W = 8;

  typedef enum logic [CMD_W-1:0] {
    CMD_READ  = 8'h00,
    CMD_WRITE = 8'h01,
    CMD_SLEEP = 8'h02,
    CMD_WAKE  = 8'h03
  } cmd_e;
endpackage

// File: rtl/dpot_pin_sync.sv
module dpot_pin_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic sdi,
  output logic sdi_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_rise,
  output logic cs_fall,
  output logic cs_act
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  // One extra stage on sck/cs gives the previous value for edge detection.
  logic [SYNC_STAGES:0]   sck_q, sck_d;
  logic [SYNC_STAGES:0]   cs_q, cs_d;
  logic [SYNC_STAGES-1:0] sdi_q, sdi_d;

  always_comb begin
    sck_d = {sck_q[SYNC_STAGES-1:0], sck};
    cs_d  = {cs_q[SYNC_STAGES-1:0], cs_n};
    sdi_d = {sdi_q[SYNC_STAGES-2:0], sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      sdi_q <= '0;
    end else begin
      sck_q <= sck_d;
      cs_q  <= cs_d;
      sdi_q <= sdi_d;
    end
  end

  assign cs_act   = ~cs_q[LAST];
  assign sdi_s    = sdi_q[LAST];
  assign sck_rise = cs_act &  sck_q[LAST] & ~sck_q[SYNC_STAGES];
  assign sck_fall = cs_act & ~sck_q[LAST] &  sck_q[SYNC_STAGES];
  assign cs_fall  = ~cs_q[LAST] &  cs_q[SYNC_STAGES];
  assign cs_rise  =  cs_q[LAST] & ~cs_q[SYNC_STAGES];
endmodule

// File: rtl/dpot_frame_shift.sv
module dpot_frame_shift
  import dpot_pkg::*;
#(
  parameter int unsigned WIPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sdi_s,
  input  logic               sck_rise,
  input  logic               sck_fall,
  input  logic               cs_rise,
  input  logic               cs_fall,
  input  logic [WIPER_W-1:0] rd_data,
  output logic               sdo,
  output logic               commit,
  output logic [CMD_W-1:0]   cmd,
  output logic [WIPER_W-1:0] data
);
  localparam int unsigned FRAME_W = CMD_W + WIPER_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               seen_q, seen_d;
  logic               sdo_q, sdo_d;
  logic               commit_q, commit_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [WIPER_W-1:0] data_q, data_d;
  logic               frame_ok;

  assign frame_ok = seen_q && (cnt_q == '0);

  always_comb begin
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    seen_d   = seen_q;
    sdo_d    = sdo_q;
    commit_d = 1'b0;
    cmd_d    = cmd_q;
    data_d   = data_q;
    if (cs_fall) begin
      cnt_d  = '0;
      seen_d = 1'b0;
      sdo_d  = shreg_q[FRAME_W-1];
    end else if (sck_rise) begin
      shreg_d = {shreg_q[FRAME_W-2:0], sdi_s};
      cnt_d   = (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
      seen_d  = 1'b1;
    end else if (sck_fall) begin
      sdo_d = shreg_q[FRAME_W-1];
    end else if (cs_rise && frame_ok) begin
      commit_d = 1'b1;
      cmd_d    = shreg_q[FRAME_W-1 -: CMD_W];
      data_d   = shreg_q[WIPER_W-1:0];
      if (shreg_q[FRAME_W-1 -: CMD_W] == CMD_READ)
        shreg_d[WIPER_W-1:0] = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q  <= '0;
      cnt_q    <= '0;
      seen_q   <= 1'b0;
      sdo_q    <= 1'b0;
      commit_q <= 1'b0;
      cmd_q    <= '0;
      data_q   <= '0;
    end else begin
      shreg_q  <= shreg_d;
      cnt_q    <= cnt_d;
      seen_q   <= seen_d;
      sdo_q    <= sdo_d;
      commit_q <= commit_d;
      cmd_q    <= cmd_d;
      data_q   <= data_d;
    end
  end

  assign sdo    = sdo_q;
  assign commit = commit_q;
  assign cmd    = cmd_q;
  assign data   = data_q;

  // R8: output bit only moves on a falling SCK or a select fall
  p_sdo_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_fall || cs_fall) |=> $stable(sdo_q));

  // R6: commits only follow a select release
  p_commit_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(cs_rise));
endmodule

// File: rtl/dpot_wiper_reg.sv
module dpot_wiper_reg
  import dpot_pkg::*;
#(
  parameter int unsigned WIPER_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [CMD_W-1:0]   cmd,
  input  logic [WIPER_W-1:0] data,
  output logic [WIPER_W-1:0] wiper,
  output logic               asleep
);
  localparam logic [WIPER_W-1:0] MID_POS = WIPER_W'(1) << (WIPER_W - 1);

  logic [WIPER_W-1:0] wiper_q, wiper_d;
  logic               asleep_q, asleep_d;

  always_comb begin
    wiper_d  = wiper_q;
    asleep_d = asleep_q;
    if (commit) begin
      unique case (cmd)
        CMD_WRITE: wiper_d  = data;
        CMD_SLEEP: asleep_d = 1'b1;
        CMD_WAKE:  asleep_d = 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q  <= MID_POS;
      asleep_q <= 1'b0;
    end else begin
      wiper_q  <= wiper_d;
      asleep_q <= asleep_d;
    end
  end

  assign wiper  = wiper_q;
  assign asleep = asleep_q;

  // R11: state holds without a commit
  p_state_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(wiper_q) && $stable(asleep_q)));

  // R5: leaving shutdown keeps the stored position
  p_wake_keeps_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd == CMD_WAKE) |=> ($stable(wiper_q) && !asleep_q));
endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
  parameter int unsigned WIPER_W = 8,
  localparam int unsigned TAPS   = 1 << WIPER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIPER_W-1:0] wiper,
  input  logic               asleep,
  output logic [TAPS-1:0]    tap_sel,
  output logic               high_en,
  output logic               wl_short
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = ~asleep & (wiper == WIPER_W'(i));
  end

  assign high_en  = ~asleep;
  assign wl_short = asleep;

  // R10: one closed tap at the stored position while active
  p_tap_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !asleep |-> ($countones(tap_sel) == 1 && tap_sel[wiper]));

  // R4: string open and wiper shorted low in shutdown
  p_shutdown_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (tap_sel == '0 && wl_short && !high_en));
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
  import dpot_pkg::*;
#(
  parameter int unsigned WIPER_W     = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TAPS       = 1 << WIPER_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spi_sck,
  input  logic            spi_cs_n,
  input  logic            spi_mosi,
  output logic            spi_miso,
  output logic            spi_miso_oe,
  output logic [TAPS-1:0] tap_sel,
  output logic            high_en,
  output logic            wl_short
);
  // Asynchronous assertion, synchronous release
  logic [1:0] rst_q;
  logic       rst_l;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_l = rst_q[1];

  logic               sdi_s, sck_rise, sck_fall, cs_rise, cs_fall, cs_act;
  logic               commit, asleep;
  logic [CMD_W-1:0]   cmd;
  logic [WIPER_W-1:0] data, wiper;

  dpot_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_l), .sck(spi_sck), .cs_n(spi_cs_n), .sdi(spi_mosi),
    .sdi_s(sdi_s), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_rise(cs_rise), .cs_fall(cs_fall), .cs_act(cs_act)
  );

  dpot_frame_shift #(.WIPER_W(WIPER_W)) i_shift (
    .clk(clk), .rst_n(rst_l), .sdi_s(sdi_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .rd_data(wiper), .sdo(spi_miso), .commit(commit), .cmd(cmd), .data(data)
  );

  dpot_wiper_reg #(.WIPER_W(WIPER_W)) i_wiper (
    .clk(clk), .rst_n(rst_l), .commit(commit), .cmd(cmd), .data(data),
    .wiper(wiper), .asleep(asleep)
  );

  dpot_tap_decode #(.WIPER_W(WIPER_W)) i_taps (
    .clk(clk), .rst_n(rst_l), .wiper(wiper), .asleep(asleep),
    .tap_sel(tap_sel), .high_en(high_en), .wl_short(wl_short)
  );

  assign spi_miso_oe = cs_act;
endmodule

// File: tb/test_dpot_ctrl.sv
module test_dpot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int TAPS       = 256;
  localparam int WDOG       = 180000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            spi_sck, spi_cs_n, spi_mosi;
  logic            spi_miso, spi_miso_oe;
  logic [TAPS-1:0] tap_sel;
  logic            high_en, wl_short;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  bit  oe_ok  = 1'b1;
  logic [31:0] rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpot_ctrl i_dpot_ctrl (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .tap_sel(tap_sel), .high_en(high_en), .wl_short(wl_short)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [TAPS-1:0] act,
                     input logic [TAPS-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] onehot(input int pos);
    logic [TAPS-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  task automatic xfer(input logic [31:0] tx, input int nbits, output logic [31:0] rxo);
    rxo = '0;
    spi_cs_n = 1'b0;
    tick(HALF);
    for (int i = nbits - 1; i >= 0; i--) begin
      spi_mosi = tx[i];
      tick(HALF);
      rxo = {rxo[30:0], spi_miso};
      if (spi_miso_oe !== 1'b1) oe_ok = 1'b0;
      spi_sck = 1'b1;
      tick(HALF);
      spi_sck = 1'b0;
    end
    tick(HALF);
    spi_cs_n = 1'b1;
    tick(4 * HALF);
  endtask

  task automatic chk_tap(input int pos, input string req);
    chk(tap_sel === onehot(pos) && high_en === 1'b1 && wl_short === 1'b0,
        req, tap_sel, onehot(pos));
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<%0d cycles", WDOG, WDOG);
    summary();
  end

  initial begin
    rst_n = 1'b0; spi_sck = 1'b0; spi_cs_n = 1'b1; spi_mosi = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    // R1: reset state; R9: output disabled while deselected
    chk_tap(128, "R1 reset tap");
    chk(spi_miso_oe === 1'b0, "R9 oe idle", TAPS'(spi_miso_oe), '0);

    // R1 / R3: read the reset value
    xfer({16'h0, 8'h00, 8'h00}, 16, rx);
    xfer({16'h0, 8'h04, 8'h00}, 16, rx);
    chk(rx[15:0] == 16'h0080, "R1 R3 reset readback", TAPS'(rx[15:0]), TAPS'(16'h0080));
    chk_tap(128, "R7 nop keeps reset tap");

    // R2 R10 R3 R8: write and read back every position
    for (int w = 0; w < TAPS; w++) begin
      xfer({16'h0, 8'h01, 8'(w)}, 16, rx);
      if (w > 0)
        chk(rx[15:0] == {8'h00, 8'(w - 1)}, "R3 readback",
            TAPS'(rx[15:0]), TAPS'({8'h00, 8'(w - 1)}));
      chk_tap(w, "R2 R10 write tap");
      xfer({16'h0, 8'h00, 8'h5A}, 16, rx);
      chk(rx[15:0] == {8'h01, 8'(w)}, "R8 echo prev frame",
          TAPS'(rx[15:0]), TAPS'({8'h01, 8'(w)}));
      chk_tap(w, "R3 R11 read keeps tap");
    end
    xfer({16'h0, 8'h04, 8'h00}, 16, rx);
    chk(rx[15:0] == 16'h00FF, "R3 last readback", TAPS'(rx[15:0]), TAPS'(16'h00FF));

    // R6: frame length rules
    xfer({16'h0, 8'h01, 8'h40}, 16, rx);
    chk_tap(64, "R2 setup");
    xfer({16'h0, 8'h01, 8'h55} >> 1, 15, rx);
    chk_tap(64, "R6 15-clock frame ignored");
    xfer({15'h0, 1'b0, 8'h01, 8'h55}, 17, rx);
    chk_tap(64, "R6 17-clock frame ignored");
    xfer(32'h0, 0, rx);
    chk_tap(64, "R6 empty frame ignored");
    xfer(32'h01AA_0133, 32, rx);
    chk_tap(8'h33, "R6 R8 32-clock frame acts on last 16");
    chk(rx[15:0] == 16'h01AA, "R8 forward first half", TAPS'(rx[15:0]), TAPS'(16'h01AA));

    // R7: every unused command code
    for (int c = 4; c < 256; c++) begin
      xfer({16'h0, 8'(c), 8'hC7}, 16, rx);
      chk_tap(8'h33, "R7 unused command");
    end

    // R4 R5: shutdown and wake
    xfer({16'h0, 8'h02, 8'h00}, 16, rx);
    chk(tap_sel === '0 && high_en === 1'b0 && wl_short === 1'b1,
        "R4 shutdown open", tap_sel, '0);
    xfer({16'h0, 8'h01, 8'h10}, 16, rx);
    chk(tap_sel === '0 && wl_short === 1'b1, "R5 write in shutdown", tap_sel, '0);
    xfer({16'h0, 8'h03, 8'h00}, 16, rx);
    chk_tap(8'h10, "R5 wake restores");

    // R9
    chk(oe_ok, "R9 oe during frames", TAPS'(oe_ok), TAPS'(1));
    chk(spi_miso_oe === 1'b0, "R9 oe after frames", TAPS'(spi_miso_oe), '0);

    summary();
  end
endmodule